// File: doc/BRIEF.md
# Indexed Display Register Port

This block is the host-facing control register file of a virtual display adapter. The host sees three 32-bit word slots. The index slot holds the number of the register the host wants to reach. The value slot reads or writes that register. The third slot is a firmware slot that always reads as zero and drops every write. Behind the value slot sits a sparse register space:
- a device version handshake,
- display enable and configuration-done controls,
- the pending mode (width, height, fixed colour depth),
- values derived from the mode, such as bits per pixel, line pitch and framebuffer size,
- a capability word,
- cursor state,
- a window of general scratch words.

The block drives the current mode, the enable and configuration flags, the cursor state and a one-cycle configuration-done pulse to the neighbouring command-queue logic. That logic returns a bounds-check verdict on `fifo_bounds_ok`, and the block samples it when the host signals configuration done. Reads take one cycle: the result appears on `rd_data` with `rd_valid` in the cycle after the request.

Top module: `disp_regport`

## Requirements
- R1: A write to slot 0 loads the 32-bit register index, and a read of slot 0 returns it. Reset sets to zero the index, the device ID, enable, the configuration flag, width, height, framebuffer size and all cursor state.
- R2: For a read request, `rd_valid` is high with the data in the following cycle and low otherwise. Slot 2 always reads zero and its writes change nothing.
- R3: Register 0 holds the device ID. A write is taken only when the value equals 0x9000_0000, 0x9000_0001 or 0x9000_0002. Any other value leaves the ID unchanged.
- R4: Register 1 is enable, and reads back 1 or 0. Writing zero clears both enable and the configuration flag. Every write to it loads the framebuffer size with ceil(depth/8) × width × height, truncated to 32 bits.
- R5: Registers 2 and 3 store the pending width and height. They read back and drive `mode_width` and `mode_height`.
- R6: Register 4 reads MAX_W (2360) and register 5 reads MAX_H (1770). Writes to either do not change what they read.
- R7: Register 6 reads HOST_DEPTH, and any depth write leaves it unchanged. Registers 7 and 28 both read the depth rounded up to a multiple of 8.
- R8: Register 12 reads ceil(depth/8) × pending width. Register 16 reads the framebuffer size, which is also driven on `fb_size`.
- R9: Register 17 reads a capability word. Bit 0 (fill) and bit 1 (copy) are always set. Bits 5, 6 and 7 are set only while `cursor_hw_present` is high. All other bits are zero.
- R10: A write to register 20 loads the configuration flag from `fifo_bounds_ok` and raises `cfg_done_pulse` for exactly one cycle. A read of register 20 returns the flag.
- R11: Registers 24, 25 and 26 store the cursor id, x and y. Writing register 27 with 1 shows the cursor and with 0 hides it. Values 2 and 3 leave visibility unchanged.
- R12: Registers 1792 to 1792+SCRATCH_WORDS−1 are read/write scratch words. Register 29 reads SCRATCH_WORDS.
- R13: Any other index, including 30–32, 1024–1791 and the indices past the scratch window, reads zero. Writes to these indices change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Word slot: 0 index, 1 value, 2 firmware |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid (one cycle after request) |
| fifo_bounds_ok | input | 1 | Bounds verdict from command-queue logic |
| cursor_hw_present | input | 1 | Hardware cursor available |
| mode_width | output | 32 | Pending width |
| mode_height | output | 32 | Pending height |
| fb_size | output | 32 | Framebuffer bytes, latched on enable write |
| display_en | output | 1 | Display enabled |
| config_ok | output | 1 | Configuration accepted |
| cfg_done_pulse | output | 1 | One-cycle configuration-done strobe |
| cursor_vis | output | 1 | Cursor visible |
| cursor_id | output | 32 | Cursor identifier |
| cursor_x | output | 32 | Cursor x |
| cursor_y | output | 32 | Cursor y |

## Verification
The bench builds the block with HOST_DEPTH = 15 and SCRATCH_WORDS = 16. A depth of 15 is not a multiple of 8, so both the rounding to 16 bits per pixel and the two-bytes-per-pixel scaling of pitch and framebuffer size are exercised. The 16-word window is small enough to fill entirely and to probe at both edges. Writes just past the window's end are checked so that they do not alias onto low scratch words through a truncated address.

// File: rtl/disp_regport_pkg.sv
package disp_regport_pkg;
  localparam logic [31:0] IX_ID       = 32'd0;
  localparam logic [31:0] IX_ENABLE   = 32'd1;
  localparam logic [31:0] IX_WIDTH    = 32'd2;
  localparam logic [31:0] IX_HEIGHT   = 32'd3;
  localparam logic [31:0] IX_MAXW     = 32'd4;
  localparam logic [31:0] IX_MAXH     = 32'd5;
  localparam logic [31:0] IX_DEPTH    = 32'd6;
  localparam logic [31:0] IX_BPP      = 32'd7;
  localparam logic [31:0] IX_PITCH    = 32'd12;
  localparam logic [31:0] IX_FBSIZE   = 32'd16;
  localparam logic [31:0] IX_CAPS     = 32'd17;
  localparam logic [31:0] IX_CFGDONE  = 32'd20;
  localparam logic [31:0] IX_CUR_ID   = 32'd24;
  localparam logic [31:0] IX_CUR_X    = 32'd25;
  localparam logic [31:0] IX_CUR_Y    = 32'd26;
  localparam logic [31:0] IX_CUR_ON   = 32'd27;
  localparam logic [31:0] IX_HOSTBPP  = 32'd28;
  localparam logic [31:0] IX_SCRSIZE  = 32'd29;
  localparam logic [31:0] IX_SCR_BASE = 32'd1792;

  localparam logic [23:0] ID_MAGIC  = 24'h900000;
  localparam logic [7:0]  ID_MAXVER = 8'd2;

  typedef enum logic [1:0] {
    SLOT_INDEX = 2'd0,
    SLOT_VALUE = 2'd1,
    SLOT_FW    = 2'd2,
    SLOT_NONE  = 2'd3
  } slot_e;

  function automatic logic id_legal(input logic [31:0] v);
    return (v[31:8] == ID_MAGIC) && (v[7:0] <= ID_MAXVER);
  endfunction
endpackage

// File: rtl/disp_scratch_ram.sv
module disp_scratch_ram #(
  parameter int WORDS = 256,
  parameter int DW    = 32,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/disp_mode_calc.sv
module disp_mode_calc #(
  parameter int HOST_DEPTH = 24
) (
  input  logic [31:0] width,
  input  logic [31:0] height,
  output logic [31:0] bits_pp,
  output logic [31:0] pitch,
  output logic [31:0] fb_bytes
);
  localparam int BYTES_PP = (HOST_DEPTH + 7) / 8;
  localparam logic [31:0] BYTES_PP_W = 32'(BYTES_PP);

  always_comb begin
    bits_pp  = BYTES_PP_W << 3;
    pitch    = BYTES_PP_W * width;
    fb_bytes = BYTES_PP_W * width * height;
  end
endmodule

// File: rtl/disp_regport.sv
module disp_regport
  import disp_regport_pkg::*;
#(
  parameter int HOST_DEPTH    = 24,
  parameter int SCRATCH_WORDS = 256,
  parameter int MAX_W         = 2360,
  parameter int MAX_H         = 1770
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [1:0]  acc_addr,
  input  logic [31:0] acc_wdata,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  input  logic        fifo_bounds_ok,
  input  logic        cursor_hw_present,
  output logic [31:0] mode_width,
  output logic [31:0] mode_height,
  output logic [31:0] fb_size,
  output logic        display_en,
  output logic        config_ok,
  output logic        cfg_done_pulse,
  output logic        cursor_vis,
  output logic [31:0] cursor_id,
  output logic [31:0] cursor_x,
  output logic [31:0] cursor_y
);
  localparam int SAW = (SCRATCH_WORDS > 1) ? $clog2(SCRATCH_WORDS) : 1;
  localparam logic [31:0] SCR_END = IX_SCR_BASE + 32'(SCRATCH_WORDS);

  logic [31:0] idx_q, id_q;
  logic [31:0] bits_pp, pitch, fb_bytes;
  logic [31:0] rdq, reg_rd, ram_q;
  logic        scr_sel_q, in_scr;
  logic        wr_idx, wr_val, rd_req;
  logic [SAW-1:0] scr_addr;
  logic [31:0] caps;

  assign wr_idx = acc_valid &&  acc_write && (slot_e'(acc_addr) == SLOT_INDEX);
  assign wr_val = acc_valid &&  acc_write && (slot_e'(acc_addr) == SLOT_VALUE);
  assign rd_req = acc_valid && !acc_write;

  assign in_scr   = (idx_q >= IX_SCR_BASE) && (idx_q < SCR_END);
  assign scr_addr = SAW'(idx_q - IX_SCR_BASE);

  disp_mode_calc #(.HOST_DEPTH(HOST_DEPTH)) u_calc (
    .width(mode_width), .height(mode_height),
    .bits_pp(bits_pp), .pitch(pitch), .fb_bytes(fb_bytes)
  );

  disp_scratch_ram #(.WORDS(SCRATCH_WORDS), .DW(32)) u_scr (
    .clk(clk), .we(wr_val && in_scr), .waddr(scr_addr),
    .wdata(acc_wdata), .raddr(scr_addr), .rdata(ram_q)
  );

  assign caps = {24'd0, {3{cursor_hw_present}}, 3'b000, 2'b11};

  always_comb begin
    reg_rd = 32'd0;
    unique case (idx_q)
      IX_ID:      reg_rd = id_q;
      IX_ENABLE:  reg_rd = {31'd0, display_en};
      IX_WIDTH:   reg_rd = mode_width;
      IX_HEIGHT:  reg_rd = mode_height;
      IX_MAXW:    reg_rd = 32'(MAX_W);
      IX_MAXH:    reg_rd = 32'(MAX_H);
      IX_DEPTH:   reg_rd = 32'(HOST_DEPTH);
      IX_BPP:     reg_rd = bits_pp;
      IX_PITCH:   reg_rd = pitch;
      IX_FBSIZE:  reg_rd = fb_size;
      IX_CAPS:    reg_rd = caps;
      IX_CFGDONE: reg_rd = {31'd0, config_ok};
      IX_CUR_ID:  reg_rd = cursor_id;
      IX_CUR_X:   reg_rd = cursor_x;
      IX_CUR_Y:   reg_rd = cursor_y;
      IX_CUR_ON:  reg_rd = {31'd0, cursor_vis};
      IX_HOSTBPP: reg_rd = bits_pp;
      IX_SCRSIZE: reg_rd = 32'(SCRATCH_WORDS);
      default:    reg_rd = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      rdq       <= 32'd0;
      scr_sel_q <= 1'b0;
    end else begin
      rd_valid  <= rd_req;
      scr_sel_q <= 1'b0;
      if (rd_req) begin
        unique case (slot_e'(acc_addr))
          SLOT_INDEX: rdq <= idx_q;
          SLOT_VALUE: begin
            rdq       <= reg_rd;
            scr_sel_q <= in_scr;
          end
          default:    rdq <= 32'd0;
        endcase
      end
    end
  end

  assign rd_data = scr_sel_q ? ram_q : rdq;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q          <= 32'd0;
      id_q           <= 32'd0;
      display_en     <= 1'b0;
      config_ok      <= 1'b0;
      cfg_done_pulse <= 1'b0;
      mode_width     <= 32'd0;
      mode_height    <= 32'd0;
      fb_size        <= 32'd0;
      cursor_vis     <= 1'b0;
      cursor_id      <= 32'd0;
      cursor_x       <= 32'd0;
      cursor_y       <= 32'd0;
    end else begin
      cfg_done_pulse <= 1'b0;
      if (wr_idx) idx_q <= acc_wdata;
      if (wr_val) begin
        unique case (idx_q)
          IX_ID:      if (id_legal(acc_wdata)) id_q <= acc_wdata;
          IX_ENABLE: begin
            display_en <= (acc_wdata != 32'd0);
            if (acc_wdata == 32'd0) config_ok <= 1'b0;
            fb_size <= fb_bytes;
          end
          IX_WIDTH:   mode_width  <= acc_wdata;
          IX_HEIGHT:  mode_height <= acc_wdata;
          IX_CFGDONE: begin
            config_ok      <= fifo_bounds_ok;
            cfg_done_pulse <= 1'b1;
          end
          IX_CUR_ID:  cursor_id <= acc_wdata;
          IX_CUR_X:   cursor_x  <= acc_wdata;
          IX_CUR_Y:   cursor_y  <= acc_wdata;
          IX_CUR_ON: begin
            if (acc_wdata == 32'd1) cursor_vis <= 1'b1;
            else if (acc_wdata == 32'd0) cursor_vis <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/disp_regport_chk.sv
module disp_regport_chk (
  input logic        clk,
  input logic        rst,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [1:0]  acc_addr,
  input logic [31:0] acc_wdata,
  input logic [31:0] idx,
  input logic [31:0] dev_id,
  input logic        rd_valid,
  input logic        display_en,
  input logic        config_ok,
  input logic        cfg_done_pulse,
  input logic        cursor_vis
);
  logic val_wr;
  assign val_wr = acc_valid && acc_write && (acc_addr == 2'd1);

  // R2
  rd_valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rd_valid == $past(acc_valid && !acc_write)));

  // R3
  id_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(dev_id)) |->
      (dev_id[31:8] == 24'h900000 && dev_id[7:0] <= 8'd2));

  // R4
  en_drop_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(display_en) |-> !config_ok);

  // R10
  cfg_pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cfg_done_pulse) |-> $past(val_wr && idx == 32'd20));

  // R11
  cursor_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(cursor_vis)) |->
      $past(val_wr && idx == 32'd27 && acc_wdata <= 32'd1));
endmodule

bind disp_regport disp_regport_chk u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .idx(idx_q), .dev_id(id_q),
  .rd_valid(rd_valid), .display_en(display_en), .config_ok(config_ok),
  .cfg_done_pulse(cfg_done_pulse), .cursor_vis(cursor_vis)
);

// File: tb/tb_disp_regport.sv
module tb_disp_regport;
  localparam int DEPTH = 15;
  localparam int SW    = 16;
  localparam int BPPX  = (DEPTH + 7) / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0] acc_addr = 2'd0;
  logic [31:0] acc_wdata = 32'd0;
  logic fifo_bounds_ok = 1'b0, cursor_hw_present = 1'b1;
  logic [31:0] rd_data, mode_width, mode_height, fb_size, cursor_id, cursor_x, cursor_y;
  logic rd_valid, display_en, config_ok, cfg_done_pulse, cursor_vis;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [31:0] m_scr [SW];
  logic [31:0] m_w = 0, m_h = 0, m_fb = 0;
  logic m_vis = 0;

  always #4 clk = ~clk;

  disp_regport #(.HOST_DEPTH(DEPTH), .SCRATCH_WORDS(SW)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] a, input logic [31:0] d,
                     output logic [31:0] q, output logic v);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
    q = rd_data; v = rd_valid;
  endtask

  task automatic rw(input logic [31:0] ix, input logic [31:0] d);
    logic [31:0] q; logic v;
    acc(1'b1, 2'd0, ix, q, v);
    acc(1'b1, 2'd1, d, q, v);
  endtask

  task automatic rr(input logic [31:0] ix, output logic [31:0] q);
    logic v;
    acc(1'b1, 2'd0, ix, q, v);
    acc(1'b0, 2'd1, 32'd0, q, v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] q; logic v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 reset en", {31'd0, display_en}, 0);
    chk("R1 reset cfg", {31'd0, config_ok}, 0);
    chk("R1 reset fb", fb_size, 0);
    chk("R1 reset vis", {31'd0, cursor_vis}, 0);
    acc(1'b0, 2'd0, 0, q, v);
    chk("R1 reset idx", q, 0);
    rr(0, q); chk("R1 reset id", q, 0);
    acc(1'b1, 2'd0, 32'hDEAD_0123, q, v);
    acc(1'b0, 2'd0, 0, q, v);
    chk("R1 idx readback", q, 32'hDEAD_0123);
    chk("R2 rd_valid", {31'd0, v}, 1);
    @(negedge clk); chk("R2 rd_valid low", {31'd0, rd_valid}, 0);
    acc(1'b1, 2'd2, 32'h1234, q, v);
    acc(1'b0, 2'd2, 0, q, v);
    chk("R2 fw slot", q, 0);
    // R3 id handshake
    rw(0, 32'h9000_0002); rr(0, q); chk("R3 id v2", q, 32'h9000_0002);
    rw(0, 32'h9000_0003); rr(0, q); chk("R3 id bad", q, 32'h9000_0002);
    rw(0, 32'h9000_0000); rr(0, q); chk("R3 id v0", q, 32'h9000_0000);
    // R5 R8 R4
    rw(2, 640); rw(3, 480);
    chk("R5 width", mode_width, 640); chk("R5 height", mode_height, 480);
    rr(3, q); chk("R5 height rd", q, 480);
    rr(12, q); chk("R8 pitch", q, 640 * BPPX);
    rw(1, 1);
    chk("R4 fb", fb_size, 640 * 480 * BPPX);
    rr(16, q); chk("R8 fb rd", q, 640 * 480 * BPPX);
    rr(1, q); chk("R4 en rd", q, 1);
    // R6 R7
    rw(4, 5); rr(4, q); chk("R6 maxw", q, 2360);
    rr(5, q); chk("R6 maxh", q, 1770);
    rw(6, 32); rr(6, q); chk("R7 depth", q, DEPTH);
    rr(7, q); chk("R7 bpp", q, 16);
    rr(28, q); chk("R7 host bpp", q, 16);
    // R9
    rr(17, q); chk("R9 caps hw", q, 32'hE3);
    cursor_hw_present = 1'b0;
    rr(17, q); chk("R9 caps nohw", q, 32'h03);
    // R10 config done pulse
    fifo_bounds_ok = 1'b1;
    acc(1'b1, 2'd0, 20, q, v);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 2'd1; acc_wdata = 0;
    @(negedge clk); acc_valid = 1'b0;
    chk("R10 pulse", {31'd0, cfg_done_pulse}, 1);
    chk("R10 cfg", {31'd0, config_ok}, 1);
    @(negedge clk); chk("R10 pulse one", {31'd0, cfg_done_pulse}, 0);
    rr(20, q); chk("R10 cfg rd", q, 1);
    rw(1, 0);
    chk("R4 en clr", {31'd0, display_en}, 0);
    chk("R4 cfg clr", {31'd0, config_ok}, 0);
    fifo_bounds_ok = 1'b0; rw(20, 0); chk("R10 bad bounds", {31'd0, config_ok}, 0);
    // R11 cursor
    rw(24, 7); rw(25, 100); rw(26, 200);
    chk("R11 id", cursor_id, 7); chk("R11 x", cursor_x, 100); chk("R11 y", cursor_y, 200);
    rw(27, 1); chk("R11 show", {31'd0, cursor_vis}, 1);
    rw(27, 2); chk("R11 keep2", {31'd0, cursor_vis}, 1);
    rw(27, 0); chk("R11 hide", {31'd0, cursor_vis}, 0);
    rw(27, 3); chk("R11 keep3", {31'd0, cursor_vis}, 0);
    // R12 scratch fill and edges
    rr(29, q); chk("R12 size", q, SW);
    for (int i = 0; i < SW; i++) begin
      m_scr[i] = $urandom; rw(1792 + i, m_scr[i]);
    end
    rr(1792, q); chk("R12 first", q, m_scr[0]);
    rr(1792 + SW - 1, q); chk("R12 last", q, m_scr[SW-1]);
    // R13 unknown indices
    rw(1792 + SW, 32'hBAD0_BAD0); rr(1792, q); chk("R13 no alias", q, m_scr[0]);
    rr(1792 + SW, q); chk("R13 past window", q, 0);
    rw(31, 9); rr(31, q); chk("R13 idx31", q, 0);
    rw(1500, 9); rr(1500, q); chk("R13 palette", q, 0);
    rr(1024, q); chk("R13 pal lo", q, 0);
    rr(1791, q); chk("R13 pal hi", q, 0);
    // constrained random mix
    m_vis = 0;
    for (int n = 0; n < 120; n++) begin
      int op = $urandom % 4;
      if (op == 0) begin
        m_w = $urandom % 4096; m_h = $urandom % 4096;
        rw(2, m_w); rw(3, m_h); rw(1, 1 + $urandom % 5);
        chk("R4 rand fb", fb_size, m_w * m_h * BPPX);
        rr(12, q); chk("R8 rand pitch", q, m_w * BPPX);
      end else if (op == 1) begin
        int a = $urandom % SW;
        m_scr[a] = $urandom; rw(1792 + a, m_scr[a]);
        rr(1792 + a, q); chk("R12 rand scr", q, m_scr[a]);
      end else if (op == 2) begin
        logic [31:0] cv = $urandom % 4;
        if (cv == 1) m_vis = 1; else if (cv == 0) m_vis = 0;
        rw(27, cv); rr(27, q); chk("R11 rand vis", q, {31'd0, m_vis});
      end else begin
        logic [31:0] ix;
        case ($urandom % 3)
          0: ix = 30 + $urandom % 3;
          1: ix = 1024 + $urandom % 768;
          default: ix = 1792 + SW + $urandom % 200;
        endcase
        rw(ix, $urandom); rr(ix, q); chk("R13 rand unk", q, 0);
      end
    end
    for (int i = 0; i < SW; i++) begin
      rr(1792 + i, q); chk("R12 final scr", q, m_scr[i]);
    end
    finish_run();
  end
endmodule